// File: doc/BRIEF.md
# Audio Frame Sequencer with Delayed Restart

This block paces the slow modulation units of a retro sound processor. It runs on the CPU clock and counts cycles through a fixed sequence. At chosen counts it emits a one-cycle quarter-frame pulse to the envelope units and a one-cycle half-frame pulse to the length and sweep units. In one of its two modes it also raises a sticky frame interrupt flag near the end of each pass.

Software picks the mode and the interrupt inhibit with a single byte write. The write restarts the sequence, but not at once. The restart lands three or four cycles later, depending on the parity of the cycle that carries the write. The new mode is taken on at the moment of the restart. The inhibit bit acts at the write edge itself. A status-read acknowledge clears the interrupt flag.

Top module: `audio_frame_seq`

## Requirements
- R1: While rst_i is high and on the first cycle after it falls, qf_o, hf_o and irq_o are low. The sequence then starts in four-step mode as if it had restarted on the last reset edge, and the cycle right after reset has even parity.
- R2: Counting edges from the start edge S of a sequence, the position of an edge is its number of edges after S. In four-step mode qf_o is high for one cycle after edge S+P+2, for P in {7457, 14913, 22371, 29829}, and is low on the edges around those.
- R3: hf_o pulses only together with qf_o. In four-step mode it pulses for P in {14913, 29829}.
- R4: A four-step sequence repeats every 29830 cycles, so the first quarter pulse of the next pass follows edge S+29830+7459.
- R5: In five-step mode qf_o pulses for P in {7457, 14913, 22371, 37281}, and hf_o for P in {14913, 37281}. Nothing pulses for P=29829. The sequence repeats every 37282 cycles.
- R6: In four-step mode without inhibit, irq_o goes high after edge S+29829 and stays high. Five-step mode never raises irq_o.
- R7: ack_i high for one cycle clears irq_o at that edge, unless a set position falls in the same cycle.
- R8: Bit 7 of wdata_i selects the mode (0 four-step, 1 five-step). Bit 6 sets the inhibit. A write with bit 6 set clears irq_o at its own edge and holds it low. Quarter and half pulses still occur while inhibit is set.
- R9: Let a write be sampled at edge E. The cycle that follows the n-th edge after reset has parity n mod 2. If that cycle is even, the restart edge is S=E+3; if it is odd, S=E+4. The new mode applies from S onwards.
- R10: A write that selects five-step mode also produces a one-cycle pulse on both qf_o and hf_o after edge S+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_i | input | 1 | Control byte write strobe |
| wdata_i | input | 8 | Control byte: bit 7 mode, bit 6 interrupt inhibit |
| ack_i | input | 1 | Status-read acknowledge, clears the interrupt flag |
| qf_o | output | 1 | Quarter-frame pulse |
| hf_o | output | 1 | Half-frame pulse |
| irq_o | output | 1 | Frame interrupt flag |

## Verification
The hardest case to reach is the choice between the three-cycle and the four-cycle restart delay. The ports expose no parity, so the stimulus tracks the edge count since reset by itself. It places one control write on an even cycle and another on an odd cycle. It then measures where the first quarter pulse lands relative to the write, one edge either side. The interrupt flag is sticky, so the inhibit clear is tested only after the flag has been raised by a full four-step pass.

// File: rtl/afs_pkg.sv
package afs_pkg;

  typedef enum logic {
    SEQ_FOUR = 1'b0,
    SEQ_FIVE = 1'b1
  } seq_mode_e;

  // length of one pass in CPU cycles
  function automatic int seq_len(input seq_mode_e m, input int len_four, input int len_five);
    return (m == SEQ_FIVE) ? len_five : len_four;
  endfunction

  // last quarter position depends on the mode
  function automatic int last_step(input seq_mode_e m, input int q4_four, input int q4_five);
    return (m == SEQ_FIVE) ? q4_five : q4_four;
  endfunction

  function automatic logic hit_quarter(input seq_mode_e m, input int c, input int q1,
                                       input int q2, input int q3, input int q4_four,
                                       input int q4_five);
    return (c == q1) || (c == q2) || (c == q3) || (c == last_step(m, q4_four, q4_five));
  endfunction

  function automatic logic hit_half(input seq_mode_e m, input int c, input int q2,
                                    input int q4_four, input int q4_five);
    return (c == q2) || (c == last_step(m, q4_four, q4_five));
  endfunction

  function automatic logic hit_irq(input seq_mode_e m, input int c, input int first,
                                   input int len_four);
    return (m == SEQ_FOUR) && (c >= first) && (c <= len_four);
  endfunction

  // restart delay: one cycle longer when the write lands on an odd cycle
  function automatic int restart_delay(input logic odd_cycle, input int even_delay);
    return odd_cycle ? even_delay + 1 : even_delay;
  endfunction

endpackage

// File: rtl/afs_write_ctrl.sv
module afs_write_ctrl
  import afs_pkg::*;
#(
  parameter int DLY_EVEN = 3,
  parameter int MODE_BIT = 7,
  parameter int INH_BIT  = 6,
  parameter int DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              apply_o,
  output seq_mode_e         new_mode_o,
  output logic              inhibit_o,
  output logic              inh_clr_o
);
  localparam int DLY_W = $clog2(DLY_EVEN + 2);

  logic             par_q;
  logic             pend_q;
  logic [DLY_W-1:0] dly_q;
  seq_mode_e        pmode_q;
  logic             inh_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      par_q   <= 1'b0;
      pend_q  <= 1'b0;
      dly_q   <= '0;
      pmode_q <= SEQ_FOUR;
      inh_q   <= 1'b0;
    end else begin
      par_q <= ~par_q;
      if (wr_i) begin
        pend_q  <= 1'b1;
        dly_q   <= DLY_W'(restart_delay(par_q, DLY_EVEN));
        pmode_q <= seq_mode_e'(wdata_i[MODE_BIT]);
        inh_q   <= wdata_i[INH_BIT];
      end else if (pend_q) begin
        if (dly_q == DLY_W'(1)) pend_q <= 1'b0;
        else dly_q <= dly_q - DLY_W'(1);
      end
    end
  end

  assign apply_o    = pend_q && (dly_q == DLY_W'(1)) && !wr_i;
  assign new_mode_o = pmode_q;
  assign inhibit_o  = inh_q;
  assign inh_clr_o  = wr_i && wdata_i[INH_BIT];

  // R9: delay loaded from the parity of the write cycle
  p_delay_even_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_i && !par_q) |=> (pend_q && dly_q == DLY_W'(DLY_EVEN)));
  p_delay_odd_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_i && par_q) |=> (pend_q && dly_q == DLY_W'(DLY_EVEN + 1)));
  p_pend_counts_down_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (pend_q && !wr_i && dly_q != DLY_W'(1)) |=> (pend_q && dly_q == $past(dly_q) - DLY_W'(1)));

endmodule

// File: rtl/afs_step_counter.sv
module afs_step_counter
  import afs_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int POS_Q1    = 7457,
  parameter int POS_Q2    = 14913,
  parameter int POS_Q3    = 22371,
  parameter int POS_Q4_FOUR = 29829,
  parameter int POS_Q4_FIVE = 37281,
  parameter int POS_IRQ   = 29828,
  parameter int LEN_FOUR  = 29830,
  parameter int LEN_FIVE  = 37282
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       apply_i,
  input  seq_mode_e  mode_i,
  output seq_mode_e  mode_o,
  output logic       q_hit_o,
  output logic       h_hit_o,
  output logic       irq_hit_o
);
  logic [CNT_W-1:0] cnt_q;
  seq_mode_e        mode_q;
  logic [CNT_W-1:0] len_cur;

  assign len_cur = CNT_W'(seq_len(mode_q, LEN_FOUR, LEN_FIVE));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      mode_q <= SEQ_FOUR;
    end else if (apply_i) begin
      cnt_q  <= '0;
      mode_q <= mode_i;
    end else if (cnt_q == len_cur) begin
      cnt_q <= CNT_W'(1);   // the last count doubles as count zero
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign mode_o    = mode_q;
  assign q_hit_o   = hit_quarter(mode_q, int'(cnt_q), POS_Q1, POS_Q2, POS_Q3,
                                 POS_Q4_FOUR, POS_Q4_FIVE);
  assign h_hit_o   = hit_half(mode_q, int'(cnt_q), POS_Q2, POS_Q4_FOUR, POS_Q4_FIVE);
  assign irq_hit_o = hit_irq(mode_q, int'(cnt_q), POS_IRQ, LEN_FOUR);

  p_cnt_in_range_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= len_cur);
  p_wrap_to_one_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!apply_i && cnt_q == len_cur) |=> (cnt_q == CNT_W'(1)));
  p_restart_zero_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    apply_i |=> (cnt_q == '0 && mode_q == $past(mode_i)));

endmodule

// File: rtl/afs_frame_out.sv
module afs_frame_out
  import afs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      q_hit_i,
  input  logic      h_hit_i,
  input  logic      irq_hit_i,
  input  logic      apply_i,
  input  seq_mode_e new_mode_i,
  input  logic      inhibit_i,
  input  logic      inh_clr_i,
  input  logic      ack_i,
  output logic      qf_o,
  output logic      hf_o,
  output logic      irq_o
);
  logic force_pulse;
  logic q_stage_q, h_stage_q;
  logic qf_q, hf_q, irq_q;

  assign force_pulse = apply_i && (new_mode_i == SEQ_FIVE);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      q_stage_q <= 1'b0;
      h_stage_q <= 1'b0;
      qf_q      <= 1'b0;
      hf_q      <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      q_stage_q <= q_hit_i | force_pulse;
      h_stage_q <= h_hit_i | force_pulse;
      qf_q      <= q_stage_q;   // extra cycle for the frame triggers
      hf_q      <= h_stage_q;
      if (inh_clr_i || inhibit_i) irq_q <= 1'b0;
      else if (irq_hit_i)         irq_q <= 1'b1;
      else if (ack_i)             irq_q <= 1'b0;
    end
  end

  assign qf_o  = qf_q;
  assign hf_o  = hf_q;
  assign irq_o = irq_q;

  p_half_needs_quarter_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    hf_q |-> qf_q);
  p_irq_rise_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(irq_q) |-> $past(irq_hit_i));
  p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_i && !irq_hit_i) |=> !irq_q);
  p_inhibit_holds_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (inhibit_i || inh_clr_i) |=> !irq_q);
  p_force_pulse_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    force_pulse |=> ##1 (qf_q && hf_q));

endmodule

// File: rtl/audio_frame_seq.sv
module audio_frame_seq
  import afs_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int MODE_BIT    = 7,
  parameter int INH_BIT     = 6,
  parameter int DLY_EVEN    = 3,
  parameter int POS_Q1      = 7457,
  parameter int POS_Q2      = 14913,
  parameter int POS_Q3      = 22371,
  parameter int POS_Q4_FOUR = 29829,
  parameter int POS_Q4_FIVE = 37281,
  parameter int POS_IRQ     = 29828,
  parameter int LEN_FOUR    = 29830,
  parameter int LEN_FIVE    = 37282
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  output logic              qf_o,
  output logic              hf_o,
  output logic              irq_o
);
  logic      apply;
  seq_mode_e new_mode;
  seq_mode_e cur_mode;
  logic      inhibit;
  logic      inh_clr;
  logic      q_hit, h_hit, irq_hit;

  afs_write_ctrl #(
    .DLY_EVEN(DLY_EVEN), .MODE_BIT(MODE_BIT), .INH_BIT(INH_BIT), .DATA_W(DATA_W)
  ) u_write (
    .clk_i(clk_i), .rst_i(rst_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .apply_o(apply), .new_mode_o(new_mode), .inhibit_o(inhibit), .inh_clr_o(inh_clr)
  );

  afs_step_counter #(
    .CNT_W(CNT_W), .POS_Q1(POS_Q1), .POS_Q2(POS_Q2), .POS_Q3(POS_Q3),
    .POS_Q4_FOUR(POS_Q4_FOUR), .POS_Q4_FIVE(POS_Q4_FIVE), .POS_IRQ(POS_IRQ),
    .LEN_FOUR(LEN_FOUR), .LEN_FIVE(LEN_FIVE)
  ) u_count (
    .clk_i(clk_i), .rst_i(rst_i), .apply_i(apply), .mode_i(new_mode),
    .mode_o(cur_mode), .q_hit_o(q_hit), .h_hit_o(h_hit), .irq_hit_o(irq_hit)
  );

  afs_frame_out u_out (
    .clk_i(clk_i), .rst_i(rst_i), .q_hit_i(q_hit), .h_hit_i(h_hit),
    .irq_hit_i(irq_hit), .apply_i(apply), .new_mode_i(new_mode),
    .inhibit_i(inhibit), .inh_clr_i(inh_clr), .ack_i(ack_i),
    .qf_o(qf_o), .hf_o(hf_o), .irq_o(irq_o)
  );

  // R5: five-step mode never raises the flag
  p_no_irq_five_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (cur_mode == SEQ_FIVE && !irq_o) |=> !irq_o);

endmodule

// File: tb/audio_frame_seq_bench.sv
module audio_frame_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;
  // phase 0: four-step after even-cycle write; phase 1: five-step after odd-cycle write
  localparam int VPH [NV] = '{0,0,0,0,0,0,0,0,0,0, 1,1,1,1,1,1,1,1,1};
  localparam int VOFF[NV] = '{7458, 7459, 7460, 14915, 22373, 29828, 29829, 29831, 29832, 37289,
                              1, 2, 7458, 7459, 14915, 22373, 29831, 37283, 44741};
  // expected {qf, hf, irq}
  localparam logic [2:0] VEXP[NV] = '{3'b000, 3'b100, 3'b000, 3'b110, 3'b100, 3'b000, 3'b001,
                                      3'b111, 3'b001, 3'b101,
                                      3'b110, 3'b000, 3'b000, 3'b100, 3'b110, 3'b100, 3'b000,
                                      3'b110, 3'b100};
  localparam int VREQ[NV] = '{9, 2, 2, 3, 2, 6, 6, 3, 6, 4, 10, 10, 9, 5, 5, 5, 5, 5, 5};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic ack = 1'b0;
  logic qf, hf, irq;
  int ec;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) ec <= 0;
    else     ec <= ec + 1;
  end

  audio_frame_seq u_audio_frame_seq (
    .clk_i(clk), .rst_i(rst), .wr_i(wr), .wdata_i(wdata), .ack_i(ack),
    .qf_o(qf), .hf_o(hf), .irq_o(irq)
  );

  function automatic string tag(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input int r, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at edge %0d: {qf,hf,irq} actual %b expected %b", tag(r), ec, act, exp);
    end
  endtask

  task automatic wait_to(input int x);
    while (ec != x) @(negedge clk);
  endtask

  task automatic align(input int p);
    while ((ec % 2) != p) @(negedge clk);
  endtask

  // drive a control write in the current cycle; returns the restart edge
  task automatic do_write(input logic [7:0] d, output int start);
    int e0;
    int dl;
    dl = ((ec % 2) == 0) ? 3 : 4;
    e0 = ec + 1;
    wr = 1'b1;
    wdata = d;
    @(negedge clk);
    wr = 1'b0;
    wdata = 8'h00;
    start = e0 + dl;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired at edge %0d", ec);
    finish_run();
  end

  initial begin
    int base;
    int cur;
    int s2;
    cur = -1;
    base = 0;
    repeat (3) @(negedge clk);
    chk(1, {qf, hf, irq}, 3'b000);          // R1 during reset
    rst = 1'b0;
    @(negedge clk);
    chk(1, {qf, hf, irq}, 3'b000);          // R1 first cycle after reset
    wait_to(7458);
    chk(1, {qf, hf, irq}, 3'b000);
    wait_to(7459);
    chk(1, {qf, hf, irq}, 3'b100);          // R1 starts in four-step from reset edge

    for (int i = 0; i < NV; i++) begin
      if (VPH[i] != cur) begin
        cur = VPH[i];
        if (cur == 0) begin
          align(0);                          // even cycle -> 3-cycle delay (R9)
          do_write(8'h00, base);
        end else begin
          ack = 1'b1;
          @(negedge clk);
          ack = 1'b0;
          chk(7, {1'b0, 1'b0, irq}, 3'b000); // R7 acknowledge clears flag
          align(1);                          // odd cycle -> 4-cycle delay (R9)
          do_write(8'h80, base);
        end
      end
      wait_to(base + VOFF[i]);
      chk(VREQ[i], {qf, hf, irq}, VEXP[i]);
    end

    // R8: inhibit clears a raised flag and holds it low
    align(0);
    do_write(8'h00, base);
    wait_to(base + 29830);
    chk(6, {1'b0, 1'b0, irq}, 3'b001);
    do_write(8'h40, s2);
    chk(8, {1'b0, 1'b0, irq}, 3'b000);       // cleared at the write edge
    wait_to(s2 + 29830);
    chk(8, {qf, hf, irq}, 3'b000);
    wait_to(s2 + 29831);
    chk(8, {qf, hf, irq}, 3'b110);           // pulses continue under inhibit

    // R1: mid-run reset restarts the sequence
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(1, {qf, hf, irq}, 3'b000);
    rst = 1'b0;
    wait_to(7459);
    chk(1, {qf, hf, irq}, 3'b100);
    finish_run();
  end

endmodule